// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a single-channel countdown timer that sits on a 32-bit register bus. Software writes a reload value and a control word. The control word holds two things: an operation (one-shot load, freeze, or periodic run) and a choice of the strobe that advances the counter. Tick strobes come from outside as single-cycle enables: one external strobe and a parameterised set of internal ones. The block generates no clocks of its own.

When the counter expires, it latches a raw interrupt flag. Software reads that flag either directly or through a mask, and clears it by writing ones to an acknowledge location. The interrupt line is high while the flag is set and enabled by the mask.

Bus requests are accepted in any cycle. Read data and an error flag come back registered, one cycle after the request.

Top module: `dcount_timer`

## Requirements
- R1: After reset, the reload, control, mask and counter values are zero, the raw flag is clear, and `irq`, `bus_rvalid`, `bus_err` and `bus_rdata` are 0.
- R2: Full-word accesses use these offsets: reload 0x00 (read/write), counter 0x04 (read only), control 0x08 (read/write), mask 0x48 (read/write), acknowledge 0x4C (reads 0), raw flag 0x50 (bit 0), masked flag 0x54 (bit 0). Any other offset reads 0, and a write to it changes nothing.
- R3: An access whose byte enables are not 4'hF raises `bus_err` in the following cycle. Such a write is ignored, and such a read returns 0.
- R4: Control bits [1:0] = 0 (load) copy the reload value into the counter at the control write. Each selected tick then decrements the counter. The tick that takes it from 1 to 0 is an expiry, and afterwards the counter stays at 0.
- R5: Control bits [1:0] = 2 (run) leave the counter value unchanged at the control write. On a selected tick, a count of 1 reloads the reload value and expires, a count of 0 reloads without expiring, and any other count decrements.
- R6: Control bits [1:0] = 1 (hold) and the reserved code 3 freeze the counter.
- R7: Control bits [4:2] select the tick. Codes 4 to 7 take `tick_int[code-4]`. Codes 0 and 1 take `tick_ext`. Codes 2 and 3 give no tick.
- R8: A control write takes effect at its own clock edge. A tick arriving in the same cycle as the write is not applied.
- R9: An expiry sets raw flag bit 0. If an acknowledge arrives in the same cycle, the set wins.
- R10: A full-word write to 0x4C clears raw bit 0 when data bit 0 is 1. Writing 0 in that bit leaves the flag as it was.
- R11: The masked value is raw AND mask. `irq` equals masked bit 0, and it follows a mask write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_be | input | 4 | Byte enables; only 4'hF is a legal access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Narrow access flagged |
| tick_ext | input | 1 | External tick strobe |
| tick_int | input | 4 | Internal tick strobes |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that each tick input is a strobe that is sampled once per clock edge, that at most one bus request arrives per cycle, and that all inputs are known after reset. They also assume that software does not rewrite the reload value in the same cycle as a run-mode reload it is checked against; the property excludes that case itself.

The stimulus drives every input at the falling edge. It keeps reload values small so that expiries, reloads and the zero-count corner come up often, and it spreads control writes over every operation and source code, including the reserved ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_RSV  = 2'd3
  } op_e;

  localparam logic [7:0] OFF_RELOAD = 8'h00;
  localparam logic [7:0] OFF_COUNT  = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_MASK   = 8'h48;
  localparam logic [7:0] OFF_ACK    = 8'h4C;
  localparam logic [7:0] OFF_RAW    = 8'h50;
  localparam logic [7:0] OFF_MASKED = 8'h54;

  localparam int SRC_W = 3;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int N_INT = 4,
  parameter int SW    = 3
) (
  input  logic [SW-1:0]    src,
  input  logic             ext,
  input  logic [N_INT-1:0] ints,
  output logic             tick
);
  logic [N_INT-1:0] hit;

  for (genvar i = 0; i < N_INT; i++) begin : g_int
    assign hit[i] = ints[i] && (src == SW'(4 + i));
  end

  assign tick = (|hit) || (ext && (src <= SW'(1)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  op_e           new_op,
  input  op_e           op,
  input  logic          tick,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt,
  output logic          fire
);
  // Returns {expiry, next count}
  function automatic logic [CW:0] step(input logic [CW-1:0] c,
                                       input logic [CW-1:0] r,
                                       input op_e o,
                                       input logic t);
    logic [CW:0] res;
    res = {1'b0, c};
    if (t) begin
      case (o)
        OP_LOAD: if (c != '0) res = {(c == CW'(1)), c - CW'(1)};
        OP_RUN: begin
          if (c == '0)          res = {1'b0, r};
          else if (c == CW'(1)) res = {1'b1, r};
          else                  res = {1'b0, c - CW'(1)};
        end
        default: res = {1'b0, c};
      endcase
    end
    return res;
  endfunction

  logic [CW:0] nxt;
  assign nxt  = step(cnt, reload, op, tick);
  assign fire = !ctrl_wr && nxt[CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctrl_wr) begin
      if (new_op == OP_LOAD) cnt <= reload;
    end else begin
      cnt <= nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack_clr,
  input  logic mask_bit,
  output logic raw,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) raw <= 1'b0;
    else        raw <= fire | (raw & ~ack_clr);
  end

  assign irq = raw & mask_bit;
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import tmr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int N_INT = 4,
  parameter int CW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW/8-1:0]  bus_be,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  output logic             bus_err,
  input  logic             tick_ext,
  input  logic [N_INT-1:0] tick_int,
  output logic             irq
);
  localparam int BEW = DW / 8;

  logic          full, wr_ok, rd_req, bad_acc;
  logic          ctrl_wr, reload_wr, mask_wr, ack_wr, ack_clr;
  logic [CW-1:0] reload_q;
  logic [DW-1:0] ctrl_q, mask_q;
  logic [CW-1:0] cnt;
  logic          tick, fire, raw;
  op_e           op, new_op;

  assign full      = (bus_be == {BEW{1'b1}});
  assign wr_ok     = bus_valid && bus_write && full;
  assign rd_req    = bus_valid && !bus_write;
  assign bad_acc   = bus_valid && !full;
  assign ctrl_wr   = wr_ok && (bus_addr == AW'(OFF_CTRL));
  assign reload_wr = wr_ok && (bus_addr == AW'(OFF_RELOAD));
  assign mask_wr   = wr_ok && (bus_addr == AW'(OFF_MASK));
  assign ack_wr    = wr_ok && (bus_addr == AW'(OFF_ACK));
  assign ack_clr   = ack_wr && bus_wdata[0];
  assign op        = op_e'(ctrl_q[1:0]);
  assign new_op    = op_e'(bus_wdata[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      mask_q   <= '0;
    end else begin
      if (reload_wr) reload_q <= bus_wdata[CW-1:0];
      if (ctrl_wr)   ctrl_q   <= bus_wdata;
      if (mask_wr)   mask_q   <= bus_wdata;
    end
  end

  tmr_tick_sel #(.N_INT(N_INT), .SW(SRC_W)) u_sel (
    .src  (ctrl_q[SRC_W+1:2]),
    .ext  (tick_ext),
    .ints (tick_int),
    .tick (tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .new_op  (new_op),
    .op      (op),
    .tick    (tick),
    .reload  (reload_q),
    .cnt     (cnt),
    .fire    (fire)
  );

  tmr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .ack_clr  (ack_clr),
    .mask_bit (mask_q[0]),
    .raw      (raw),
    .irq      (irq)
  );

  function automatic logic [DW-1:0] read_mux(input logic [AW-1:0] a);
    case (a)
      AW'(OFF_RELOAD): return DW'(reload_q);
      AW'(OFF_COUNT):  return DW'(cnt);
      AW'(OFF_CTRL):   return ctrl_q;
      AW'(OFF_MASK):   return mask_q;
      AW'(OFF_RAW):    return DW'(raw);
      AW'(OFF_MASKED): return DW'(raw & mask_q[0]);
      default:         return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rdata  <= (rd_req && full) ? read_mux(bus_addr) : '0;
      bus_rvalid <= rd_req;
      bus_err    <= bad_acc;
    end
  end
endmodule

// File: rtl/dcount_timer_chk.sv
module dcount_timer_chk
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          reload_wr,
  input logic          ack_clr,
  input op_e           op,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] reload_q,
  input logic          fire,
  input logic          raw,
  input logic          bad_acc,
  input logic          bus_err
);
  assert_load_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && op == OP_LOAD && tick && cnt > CW'(1)) |=> cnt == $past(cnt) - CW'(1));

  assert_load_rests_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && op == OP_LOAD && cnt == '0) |=> cnt == '0);

  assert_run_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !reload_wr && op == OP_RUN && tick && cnt == CW'(1))
      |=> (cnt == $past(reload_q)) && raw);

  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && (op == OP_HOLD || op == OP_RSV)) |=> $stable(cnt));

  assert_expiry_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> raw);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !fire) |=> !raw);

  assert_narrow_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> bus_err);
endmodule

bind dcount_timer dcount_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_wr   (ctrl_wr),
  .reload_wr (reload_wr),
  .ack_clr   (ack_clr),
  .op        (op),
  .tick      (tick),
  .cnt       (cnt),
  .reload_q  (reload_q),
  .fire      (fire),
  .raw       (raw),
  .bad_acc   (bad_acc),
  .bus_err   (bus_err)
);

// File: tb/test_dcount_timer.sv
`timescale 1ns/1ps
module test_dcount_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic        tick_ext = 1'b0;
  logic [3:0]  tick_int = '0;
  logic        irq;

  int total = 0;
  int bad = 0;

  // Bench model of the software-visible state
  logic [31:0] m_reload = '0, m_ctrl = '0, m_mask = '0, m_cnt = '0;
  logic        m_raw = 1'b0;

  always #2 clk = ~clk;

  dcount_timer i_dcount_timer (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .tick_ext(tick_ext), .tick_int(tick_int), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic pick_tick(input logic [31:0] c, input logic te, input logic [3:0] ti);
    int code;
    code = int'(c[4:2]);
    if (code >= 4) return ti[code - 4];
    if (code < 2)  return te;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h00) return m_reload;
    if (a == 8'h04) return m_cnt;
    if (a == 8'h08) return m_ctrl;
    if (a == 8'h48) return m_mask;
    if (a == 8'h50) return {31'd0, m_raw};
    if (a == 8'h54) return {31'd0, m_raw & m_mask[0]};
    return 32'd0;
  endfunction

  // One bus cycle: drive at the falling edge, update the model at the rising edge, check at the next falling edge
  task automatic cyc(input logic v, input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic te, input logic [3:0] ti, input string tag);
    logic [31:0] exp_rd;
    logic t, ok, fire, ackc;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; bus_be = be;
    tick_ext = te; tick_int = ti;
    exp_rd = (be == 4'hF) ? model_read(a) : 32'd0;
    t  = pick_tick(m_ctrl, te, ti);
    ok = v && w && (be == 4'hF);
    fire = 1'b0;
    if (ok && a == 8'h08) begin
      if (d[1:0] == 2'd0) m_cnt = m_reload;      // R8: tick ignored on the write
    end else if (t) begin
      if (m_ctrl[1:0] == 2'd0 && m_cnt != 0) begin
        fire = (m_cnt == 1); m_cnt = m_cnt - 1;
      end else if (m_ctrl[1:0] == 2'd2) begin
        if (m_cnt <= 1) begin fire = (m_cnt == 1); m_cnt = m_reload; end
        else m_cnt = m_cnt - 1;
      end
    end
    ackc = ok && a == 8'h4C && d[0];
    m_raw = fire ? 1'b1 : (m_raw & ~ackc);
    if (ok && a == 8'h00) m_reload = d;
    if (ok && a == 8'h08) m_ctrl = d;
    if (ok && a == 8'h48) m_mask = d;
    @(posedge clk);
    @(negedge clk);
    if (v && !w) check({tag, " read"}, bus_rdata, exp_rd);
    if (v) check("R3 err flag", {31'd0, bus_err}, {31'd0, be != 4'hF});
    check("R11 irq", {31'd0, irq}, {31'd0, m_raw & m_mask[0]});
    bus_valid = 1'b0; tick_ext = 1'b0; tick_int = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, d, 4'hF, 0, 4'h0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1, 0, a, 0, 4'hF, 0, 4'h0, tag);
  endtask
  task automatic tk(input logic te, input logic [3:0] ti);
    cyc(0, 0, 0, 0, 4'hF, te, ti, "tick");
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 rvalid", {31'd0, bus_rvalid}, 0);
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h50, "R1");
    // R2 register map and unmapped offsets
    wr(8'h00, 32'd3, "R2"); rd(8'h00, "R2");
    wr(8'h48, 32'hFFFF_FFFE, "R2"); rd(8'h48, "R2");
    rd(8'h4C, "R2"); wr(8'h20, 32'hDEAD, "R2"); rd(8'h20, "R2"); rd(8'h00, "R2");
    // R3 narrow write ignored, narrow read returns 0
    cyc(1, 1, 8'h00, 32'd9, 4'h3, 0, 4'h0, "R3"); rd(8'h00, "R3");
    cyc(1, 0, 8'h00, 0, 4'h1, 0, 4'h0, "R3");
    // R4 load one-shot with source 4, R8 tick ignored on the control write
    cyc(1, 1, 8'h08, {27'd0, 3'd4, 2'd0}, 4'hF, 0, 4'h1, "R8");
    rd(8'h04, "R8");
    tk(0, 4'h1); rd(8'h04, "R4");
    tk(0, 4'h2); rd(8'h04, "R7");       // wrong strobe: no effect
    tk(0, 4'h1); tk(0, 4'h1); rd(8'h04, "R4"); rd(8'h50, "R9");
    tk(0, 4'h1); rd(8'h04, "R4");
    // R11 mask, R10 acknowledge
    wr(8'h48, 32'd1, "R11"); rd(8'h54, "R11");
    wr(8'h4C, 32'hFFFF_FFFE, "R10"); rd(8'h50, "R10");
    wr(8'h4C, 32'd1, "R10"); rd(8'h50, "R10");
    // R5 run with external source, R9 set beats ack
    wr(8'h00, 32'd2, "R5"); wr(8'h08, {27'd0, 3'd1, 2'd2}, "R5");
    tk(1, 0); rd(8'h04, "R5");            // 0 -> reload 2, no expiry
    tk(1, 0); tk(1, 0); rd(8'h04, "R5"); rd(8'h50, "R5");
    tk(1, 0);
    cyc(1, 1, 8'h4C, 32'd1, 4'hF, 1, 4'h0, "R9"); rd(8'h50, "R9");
    // R6 hold and reserved op
    wr(8'h08, {27'd0, 3'd0, 2'd1}, "R6"); tk(1, 0); rd(8'h04, "R6");
    wr(8'h08, {27'd0, 3'd0, 2'd3}, "R6"); tk(1, 0); rd(8'h04, "R6");
    // R7 reserved source
    wr(8'h08, {27'd0, 3'd2, 2'd2}, "R7"); tk(1, 4'hF); rd(8'h04, "R7");

    // Constrained random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic [3:0] ti;
      logic te;
      r  = int'($urandom % 100);
      ti = 4'($urandom) & 4'($urandom);
      te = 1'($urandom);
      if (r < 8)
        cyc(1, 1, 8'h08, {27'd0, 3'($urandom), 2'($urandom)}, 4'hF, te, ti, "R5 R6 R7");
      else if (r < 13)
        cyc(1, 1, 8'h00, 32'($urandom % 6), 4'hF, te, ti, "R2");
      else if (r < 16)
        cyc(1, 1, 8'h48, 32'($urandom), 4'hF, te, ti, "R11");
      else if (r < 22)
        cyc(1, 1, 8'h4C, 32'($urandom), 4'hF, te, ti, "R10");
      else if (r < 25)
        cyc(1, 1'($urandom), 8'h00, 32'($urandom), 4'($urandom % 15), te, ti, "R3");
      else if (r < 27)
        cyc(1, 1'($urandom), 8'h30, 32'($urandom), 4'hF, te, ti, "R2");
      else if (r < 60) begin
        logic [7:0] a;
        case ($urandom % 7)
          0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h48;
          4: a = 8'h4C; 5: a = 8'h50; default: a = 8'h54;
        endcase
        cyc(1, 0, a, 0, 4'hF, te, ti, "R4 R9");
      end else
        cyc(0, 0, 0, 0, 4'hF, te, ti, "idle");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule